// File: doc/BRIEF.md
# Serial Receiver with Line-Break Capture

This block receives asynchronous serial characters from one input line. A single-cycle enable pulse gives it sixteen time slots per bit. It confirms a start bit at the middle of the bit and samples every later bit at its midpoint. It builds characters of 5 to 8 data bits, checks an optional parity bit, and checks one or two stop bits. Each finished character goes into a 16-entry receive queue together with three flags: line break, parity mismatch and bad stop bit. A consumer empties the queue through a valid/ready pair.

A held-low line is reported once. When every sample of a character is 0, the receiver stores a single zero character with the break flag set. It then accepts nothing more until the line has been seen high again and a new start bit passes its mid-bit check. A status word collects the flags of each character that reaches the queue head. An overflow flag records characters lost to a full queue. A one-cycle clear strobe resets the whole status word.

The serial input must already be synchronous to `clk`. The line settings must not change while a character is being received.

Top module: `sio_rx_unit`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `st_brk`, `st_par`, `st_frm` and `st_ovr` are all 0.
- R2: A start bit is taken when `rxd` is low on an `os_tick` while idle. Data bits are sampled at slot 16 of each bit period, counted from the confirming slot, and assembled least-significant bit first.
- R3: `cfg_wlen` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. The unused upper bits of `out_data` read as 0.
- R4: The start bit is re-sampled on the eighth `os_tick` after it was detected. If `rxd` is high at that point, the start is discarded and no character is queued.
- R5: With `cfg_par_en`=1 and `cfg_par_stick`=0, the expected parity bit is the XOR of the data bits when `cfg_par_even`=1 and its inverse when `cfg_par_even`=0. A received parity bit that differs sets the parity flag of the character.
- R6: With `cfg_par_en`=1 and `cfg_par_stick`=1, the expected parity bit is constant: 1 when `cfg_par_even`=0 and 0 when `cfg_par_even`=1.
- R7: The framing flag is set when the first stop bit samples 0. With `cfg_two_stop`=1, the second stop bit is sampled but does not affect the framing flag.
- R8: A character whose start, data, parity and stop samples are all 0 is queued as a single entry. Its data is 0, its break and framing flags are 1, and its parity flag is 0.
- R9: After a break, no character is accepted until `rxd` has been seen high on an `os_tick` and a new start bit is then confirmed. A line that stays low produces no further entries.
- R10: When a character becomes the queue head, its break, parity and framing flags are OR-ed into `st_brk`, `st_par` and `st_frm`. The update lands one clock after the head appears, and the bits stay set until cleared.
- R11: A one-cycle pulse on `err_clr` clears `st_brk`, `st_par`, `st_frm` and `st_ovr` to 0.
- R12: The queue holds 16 characters and returns them in arrival order. A character that completes while the queue holds 16 entries is dropped, and `st_ovr` is set.
- R13: `out_valid` is 1 whenever the queue is not empty. An entry leaves on a clock where `out_valid` and `out_ready` are both 1. While the entry is not taken, `out_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial receive line, already synchronised, idle high |
| cfg_wlen | input | 2 | Data width code: 0 gives 5 bits, up to 3 giving 8 bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| cfg_par_stick | input | 1 | Constant parity bit |
| cfg_two_stop | input | 1 | Two stop bits per character |
| err_clr | input | 1 | Clears all status bits |
| out_ready | input | 1 | Consumer takes the head entry |
| out_valid | output | 1 | Queue not empty |
| out_data | output | 8 | Data of the head entry |
| st_brk | output | 1 | Sticky break status |
| st_par | output | 1 | Sticky parity status |
| st_frm | output | 1 | Sticky framing status |
| st_ovr | output | 1 | Sticky overflow status |

## Verification
The bench uses the default values: 16 slots per bit and a 16-entry queue. With these defaults, a 17th unread character actually overflows. The bench pulses `os_tick` every fourth clock, which gives 64 clocks per bit. With that spacing, a start glitch lasting four slots falls clearly before the mid-bit check, and a line held low for twelve bit periods covers a whole 8-bit break character with room to spare. The bench steps through all four data widths, both parity senses, constant parity and the two-stop-bit setting.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;
    localparam int ENT_W  = DATA_W + FLAG_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       two_stop;
        logic [1:0] wlen;
    } rx_cfg_t;

    typedef struct packed {
        logic              brk;
        logic              par;
        logic              frm;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Index of the final data bit for a width code (code 0 -> 5 bits).
    function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
        return 3'd4 + {1'b0, wlen};
    endfunction

    // Mask of the data bits that a width code keeps.
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] wlen);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i <= int'(last_bit_idx(wlen)));
        end
        return m;
    endfunction

    // Parity bit the receiver expects to see on the line.
    function automatic logic exp_parity(input logic [DATA_W-1:0] d,
                                        input logic even,
                                        input logic stick);
        if (stick) begin
            return ~even;
        end
        return even ? ^d : ~(^d);
    endfunction

endpackage

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
    import sio_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  rx_cfg_t   cfg,
    output logic      push,
    output rx_entry_t entry
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              all_low;
    logic              hold;
    logic              pbit;
    logic              fe_first;
    logic              in_second;

    logic              at_end;
    logic              brk_now;
    logic              frm_now;
    logic              par_now;
    logic [CW-1:0]     cnt_inc;

    always_comb begin
        at_end  = (cnt == LAST_CNT);
        cnt_inc = at_end ? '0 : cnt + 1'b1;
        brk_now = all_low & ~rxd;
        frm_now = in_second ? fe_first : ~rxd;
        par_now = cfg.par_en & (pbit != exp_parity(shreg, cfg.par_even, cfg.par_stick));
    end

    always_ff @(posedge clk) begin
        push <= 1'b0;
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            all_low   <= 1'b0;
            hold      <= 1'b0;
            pbit      <= 1'b0;
            fe_first  <= 1'b0;
            in_second <= 1'b0;
            entry     <= '0;
        end else if (tick) begin
            case (state)
                S_IDLE: begin
                    if (hold) begin
                        if (rxd) hold <= 1'b0;
                    end else if (!rxd) begin
                        state <= S_START;
                        cnt   <= '0;
                    end
                end
                S_START: begin
                    cnt <= cnt_inc;
                    if (cnt == MID_CNT) begin
                        if (rxd) begin
                            state <= S_IDLE;
                        end else begin
                            state   <= S_DATA;
                            cnt     <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            all_low <= 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    cnt <= cnt_inc;
                    if (at_end) begin
                        shreg[bit_idx] <= rxd;
                        all_low        <= all_low & ~rxd;
                        if (bit_idx == last_bit_idx(cfg.wlen)) begin
                            state     <= cfg.par_en ? S_PAR : S_STOP;
                            in_second <= 1'b0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                S_PAR: begin
                    cnt <= cnt_inc;
                    if (at_end) begin
                        pbit      <= rxd;
                        all_low   <= all_low & ~rxd;
                        state     <= S_STOP;
                        in_second <= 1'b0;
                    end
                end
                S_STOP: begin
                    cnt <= cnt_inc;
                    if (at_end) begin
                        if (!in_second && cfg.two_stop) begin
                            fe_first  <= ~rxd;
                            in_second <= 1'b1;
                            all_low   <= all_low & ~rxd;
                        end else begin
                            push       <= 1'b1;
                            entry.brk  <= brk_now;
                            entry.frm  <= brk_now | frm_now;
                            entry.par  <= ~brk_now & par_now;
                            entry.data <= brk_now ? '0 : shreg;
                            hold       <= brk_now;
                            state      <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8
    brk_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (push && entry.brk) |-> (entry.data == '0 && entry.frm && !entry.par));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && hold && !rxd) |=> (state == S_IDLE));

    // R3
    width_zero_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> ((entry.data & ~width_mask(cfg.wlen)) == '0));

    // R2
    push_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> !push);

endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo
    import sio_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t wr_ent,
    input  logic      rd_ready,
    output logic      valid,
    output rx_entry_t head,
    output logic      head_fresh,
    output logic      drop
);

    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] FULL_N = CNTW'(DEPTH);
    localparam logic [PW-1:0]   LAST_P = PW'(DEPTH - 1);

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wp;
    logic [PW-1:0]   rp;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] cnt_nx;
    logic            full;
    logic            wr;
    logic            pop;

    always_comb begin
        full   = (cnt == FULL_N);
        valid  = (cnt != '0);
        pop    = valid & rd_ready;
        wr     = push & ~full;
        drop   = push & full;
        cnt_nx = cnt + CNTW'(wr) - CNTW'(pop);
        head   = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp         <= '0;
            rp         <= '0;
            cnt        <= '0;
            head_fresh <= 1'b0;
        end else begin
            if (wr)  wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
            if (pop) rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
            cnt        <= cnt_nx;
            head_fresh <= (cnt_nx != '0) && (pop || cnt == '0);
        end
    end

    // R12
    full_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == FULL_N));

    // R13
    head_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd_ready) |=> (valid && $stable(head)));

endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
    import sio_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              head_fresh,
    input  logic [FLAG_W-1:0] head_flags,
    input  logic              drop,
    output logic [FLAG_W-1:0] st_err,
    output logic              st_ovr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_err <= '0;
            st_ovr <= 1'b0;
        end else begin
            st_err <= (clr ? '0 : st_err) | (head_fresh ? head_flags : '0);
            st_ovr <= (clr ? 1'b0 : st_ovr) | drop;
        end
    end

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !head_fresh && !drop) |=> (st_err == '0 && !st_ovr));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> ((st_err & $past(st_err)) == $past(st_err)));

endmodule

// File: rtl/sio_rx_unit.sv
module sio_rx_unit
    import sio_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_par_stick,
    input  logic       cfg_two_stop,
    input  logic       err_clr,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       st_brk,
    output logic       st_par,
    output logic       st_frm,
    output logic       st_ovr
);

    rx_cfg_t           cfg;
    rx_entry_t         fr_entry;
    rx_entry_t         head;
    logic              fr_push;
    logic              head_fresh;
    logic              drop;
    logic [FLAG_W-1:0] st_err;

    always_comb begin
        cfg.par_en    = cfg_par_en;
        cfg.par_even  = cfg_par_even;
        cfg.par_stick = cfg_par_stick;
        cfg.two_stop  = cfg_two_stop;
        cfg.wlen      = cfg_wlen;
    end

    sio_rx_frame #(.OSR(OSR)) u_frame (
        .clk   (clk),
        .rst   (rst),
        .tick  (os_tick),
        .rxd   (rxd),
        .cfg   (cfg),
        .push  (fr_push),
        .entry (fr_entry)
    );

    sio_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (fr_push),
        .wr_ent     (fr_entry),
        .rd_ready   (out_ready),
        .valid      (out_valid),
        .head       (head),
        .head_fresh (head_fresh),
        .drop       (drop)
    );

    sio_rx_status u_status (
        .clk        (clk),
        .rst        (rst),
        .clr        (err_clr),
        .head_fresh (head_fresh),
        .head_flags ({head.brk, head.par, head.frm}),
        .drop       (drop),
        .st_err     (st_err),
        .st_ovr     (st_ovr)
    );

    always_comb begin
        out_data = head.data;
        st_brk   = st_err[2];
        st_par   = st_err[1];
        st_frm   = st_err[0];
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !st_brk && !st_par && !st_frm && !st_ovr));

endmodule

// File: tb/sio_rx_unit_bench.sv
module sio_rx_unit_bench;

    localparam int BIT_CLK = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] c_wlen = 2'd3;
    logic       c_pen = 1'b0, c_even = 1'b0, c_stick = 1'b0, c_two = 1'b0;
    logic       err_clr = 1'b0;
    logic       out_ready = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       st_brk, st_par, st_frm, st_ovr;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;
    logic [1:0] tdiv = 2'd0;

    logic [10:0] q[$];
    logic [2:0]  mdl_st = 3'b000;
    logic        mdl_ovr = 1'b0;

    sio_rx_unit u_sio_rx_unit (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .cfg_wlen(c_wlen), .cfg_par_en(c_pen), .cfg_par_even(c_even),
        .cfg_par_stick(c_stick), .cfg_two_stop(c_two),
        .err_clr(err_clr), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data),
        .st_brk(st_brk), .st_par(st_par), .st_frm(st_frm), .st_ovr(st_ovr)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= tdiv + 2'd1;
        os_tick <= (tdiv == 2'd3);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the behavioural queue model
    always @(negedge clk) begin
        if (quiet && !rst && !done) begin
            chk("R13 out_valid vs model", out_valid, q.size() != 0);
            if (q.size() != 0) chk("R12 head data vs model", out_data, q[0][7:0]);
            chk("R10 R11 status vs model", {st_brk, st_par, st_frm, st_ovr}, {mdl_st, mdl_ovr});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic ref_par(input logic [7:0] d);
        if (c_stick) return ~c_even;
        return c_even ? ^d : ~(^d);
    endfunction

    task automatic mdl_push(input logic [10:0] e);
        if (q.size() == 16) begin
            mdl_ovr = 1'b1;
        end else begin
            if (q.size() == 0) mdl_st = mdl_st | e[10:8];
            q.push_back(e);
        end
    endtask

    task automatic bit_out(input logic v);
        rxd = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit hp, input bit pb,
                              input bit s1, input bit s2);
        int nb;
        logic [7:0] dm;
        nb = 5 + int'(c_wlen);
        dm = d & 8'((1 << nb) - 1);
        quiet = 1'b0;
        @(negedge clk);
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(d[i]);
        if (hp) bit_out(pb);
        bit_out(s1);
        if (c_two) bit_out(s2);
        bit_out(1'b1);
        mdl_push({1'b0, hp && (pb != ref_par(dm)), ~s1, dm});
        repeat (4) @(negedge clk);
        quiet = 1'b1;
    endtask

    task automatic pop_one();
        quiet = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        void'(q.pop_front());
        if (q.size() != 0) mdl_st = mdl_st | q[0][10:8];
        repeat (3) @(negedge clk);
        quiet = 1'b1;
    endtask

    task automatic do_clear();
        quiet = 1'b0;
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        mdl_st = 3'b000;
        mdl_ovr = 1'b0;
        repeat (2) @(negedge clk);
        quiet = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 status after reset", {st_brk, st_par, st_frm, st_ovr}, 4'b0000);
        quiet = 1'b1;

        // R2 8-bit characters, no parity
        send_frame(8'hA5, 0, 0, 1, 1);
        chk("R2 data 0xA5", out_data, 8'hA5);
        chk("R2 clean status", {st_brk, st_par, st_frm, st_ovr}, 4'b0000);
        send_frame(8'h3C, 0, 0, 1, 1);
        pop_one();
        chk("R2 second char after pop", out_data, 8'h3C);
        pop_one();
        chk("R13 empty after pops", out_valid, 0);

        // R3 narrower widths, upper bits zero
        for (int w = 0; w < 3; w++) begin
            c_wlen = 2'(w);
            send_frame(8'hFF, 0, 0, 1, 1);
            chk("R3 width masking", out_data, 8'((1 << (5 + w)) - 1));
            pop_one();
        end
        c_wlen = 2'd3;

        // R4 start glitch
        quiet = 1'b0;
        @(negedge clk);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        quiet = 1'b1;
        chk("R4 glitch rejected", out_valid, 0);

        // R5 even and odd parity
        c_pen = 1'b1; c_even = 1'b1;
        send_frame(8'h07, 1, 1'b1, 1, 1);
        chk("R5 even parity ok", st_par, 0);
        pop_one();
        send_frame(8'h07, 1, 1'b0, 1, 1);
        chk("R5 even parity mismatch", st_par, 1);
        pop_one();
        do_clear();
        c_even = 1'b0;
        send_frame(8'h07, 1, 1'b0, 1, 1);
        chk("R5 odd parity ok", st_par, 0);
        pop_one();

        // R6 stick parity
        c_stick = 1'b1;
        send_frame(8'h12, 1, 1'b1, 1, 1);
        chk("R6 stick odd expects 1", st_par, 0);
        pop_one();
        c_even = 1'b1;
        send_frame(8'h12, 1, 1'b1, 1, 1);
        chk("R6 stick even expects 0", st_par, 1);
        pop_one();
        do_clear();
        c_pen = 1'b0; c_stick = 1'b0; c_even = 1'b0;

        // R7 framing
        send_frame(8'h81, 0, 0, 0, 1);
        chk("R7 bad stop bit", st_frm, 1);
        chk("R7 data kept", out_data, 8'h81);
        pop_one();
        do_clear();
        c_two = 1'b1;
        send_frame(8'h55, 0, 0, 1, 0);
        chk("R7 second stop ignored", st_frm, 0);
        pop_one();
        c_two = 1'b0;

        // R11 clear with pending head flags
        send_frame(8'h40, 0, 0, 0, 1);
        chk("R10 framing flag latched", st_frm, 1);
        do_clear();
        chk("R11 cleared while head pending", {st_brk, st_par, st_frm, st_ovr}, 4'b0000);
        pop_one();

        // R8 R9 break
        quiet = 1'b0;
        @(negedge clk);
        rxd = 1'b0;
        repeat (12 * BIT_CLK) @(negedge clk);
        mdl_push(11'b101_0000_0000);
        quiet = 1'b1;
        repeat (6 * BIT_CLK) @(negedge clk);
        chk("R8 break status", {st_brk, st_par, st_frm, st_ovr}, 4'b1010);
        chk("R8 break data zero", out_data, 8'h00);
        chk("R9 one entry during low line", q.size(), 1);
        rxd = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        send_frame(8'h6B, 0, 0, 1, 1);
        pop_one();
        chk("R9 reception resumes", out_data, 8'h6B);
        pop_one();
        do_clear();

        // R12 overflow
        for (int i = 0; i < 17; i++) send_frame(8'(i + 8'h20), 0, 0, 1, 1);
        chk("R12 overflow flag", st_ovr, 1);
        chk("R12 model depth", q.size(), 16);
        for (int i = 0; i < 16; i++) begin
            chk("R12 order after overflow", out_data, 8'(i + 8'h20));
            pop_one();
        end
        chk("R13 drained", out_valid, 0);
        do_clear();
        chk("R11 overflow cleared", st_ovr, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule